// File: doc/BRIEF.md
# Transmit Flow-Control Credit Tracker

This block tracks the transmit flow-control credits of one virtual channel for three credit types: posted headers, posted data and non-posted headers. An initialization strobe loads the credit amounts advertised by the link partner. A credit type advertised as infinite stays infinite until the next initialization or reset. Per-cycle return inputs give credits back. A packet-accepted strobe, carrying the packet kind and its payload length in bytes, takes credits away.

The block drives an 11-bit status word that the application reads before it offers a packet. From this word the application can send the packet as it is, split a large posted write to fit the data credits on hand, or send a different kind of packet first. Header types are reported as a single "at least one packet fits" flag. Posted data is reported as an exact credit count, clamped at 256. One data credit is 16 bytes, so 256 credits cover a 4 KB payload. The status word is a direct decode of the counter registers. An accept therefore shows up in the status word in the cycle after the strobe.

Top module: `txfc_credit_tracker`

## Requirements
- R1: Status bit 0 is 1 exactly when the posted-header counter is nonzero or posted headers are infinite, and 0 otherwise.
- R2: Status bits 9:1 give the posted-data credit count as an unsigned value, clamped to 256 when the internal count is larger. Values 257 to 511 never appear.
- R3: Status bit 10 follows the rule of R1, applied to the non-posted-header counter.
- R4: An accepted posted packet (kind 0) of L payload bytes consumes one posted-header credit and ceil(L/16) posted-data credits. The status word shows the deduction in the cycle after the accept.
- R5: An accepted non-posted packet (kind 1) consumes one non-posted-header credit. Its length is ignored and it touches no posted counter.
- R6: A credit type loaded as infinite reports its maximum (flag 1, or 256 for data). Accepts and returns leave it unchanged.
- R7: A return and a consumption in the same cycle are applied together. The return is added first, then the consumption is subtracted.
- R8: Counters saturate at their maximum (255 for headers, 4095 for data) when returns would exceed it.
- R9: A consumption larger than the credits available (after the same-cycle return) sets the counter to 0 and sets the error output. The error output stays at 1 until reset.
- R10: Synchronous active-high reset clears all counters, all infinite flags and the error output, so the status word is 0.
- R11: An initialization strobe loads the advertised values and infinite flags. It overrides any accept or return in the same cycle, which are then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_load | input | 1 | Load advertised credits |
| adv_ph | input | 8 | Advertised posted-header credits |
| adv_pd | input | 12 | Advertised posted-data credits |
| adv_nph | input | 8 | Advertised non-posted-header credits |
| adv_ph_inf | input | 1 | Posted headers infinite |
| adv_pd_inf | input | 1 | Posted data infinite |
| adv_nph_inf | input | 1 | Non-posted headers infinite |
| rtn_ph | input | 8 | Posted-header credits returned this cycle |
| rtn_pd | input | 12 | Posted-data credits returned this cycle |
| rtn_nph | input | 8 | Non-posted-header credits returned this cycle |
| pkt_accept | input | 1 | A packet was accepted this cycle |
| pkt_kind | input | 1 | 0 = posted, 1 = non-posted |
| pkt_len_bytes | input | 13 | Payload length in bytes |
| credit_status | output | 11 | {nph flag, pd count[8:0], ph flag} |
| credit_uflow_err | output | 1 | Sticky underflow error |

## Verification
Credit returns and packet consumption can land in the same cycle. The bench provokes this on nearly every cycle of its length sweeps: each posted accept of a new length comes with a return amount that varies with that length. Each result is judged against an arithmetic model that adds the return, saturates, then subtracts. The sweep crosses the 256 clamp, the saturation ceiling and the zero floor. The bench also places an initialization in the same cycle as an accept and a return, and checks that the initialization wins.

// File: rtl/txfc_pkg.sv
package txfc_pkg;

    typedef enum logic {
        PKT_POSTED    = 1'b0,
        PKT_NONPOSTED = 1'b1
    } pkt_kind_e;

    localparam int PD_FIELD_W   = 9;
    localparam int PD_FIELD_MAX = 256;
    localparam int BYTES_PER_DC = 16;

    typedef struct packed {
        logic                  nph_ok;
        logic [PD_FIELD_W-1:0] pd_cnt;
        logic                  ph_ok;
    } credit_status_t;

    function automatic logic [PD_FIELD_W-1:0] clamp_pd_field(input logic [31:0] cnt);
        if (cnt > 32'(PD_FIELD_MAX))
            return PD_FIELD_W'(PD_FIELD_MAX);
        return cnt[PD_FIELD_W-1:0];
    endfunction

endpackage

// File: rtl/txfc_len2cred.sv
module txfc_len2cred #(
    parameter int LEN_W = 13,
    parameter int OUT_W = 12
) (
    input  logic [LEN_W-1:0] len_bytes,
    output logic [OUT_W-1:0] credits
);
    localparam int SUM_W = LEN_W + 1;
    localparam int SHIFT = $clog2(txfc_pkg::BYTES_PER_DC);

    logic [SUM_W-1:0] rounded;

    always_comb begin
        rounded = {1'b0, len_bytes} + SUM_W'(txfc_pkg::BYTES_PER_DC - 1);
        credits = OUT_W'(rounded >> SHIFT);
    end
endmodule

// File: rtl/txfc_credit_ctr.sv
module txfc_credit_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         load_inf,
    input  logic [W-1:0] ret_amt,
    input  logic [W-1:0] use_amt,
    output logic [W-1:0] cnt,
    output logic         inf,
    output logic         uflow
);
    localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

    logic [W-1:0] cnt_q;
    logic         inf_q;
    logic [W:0]   sum;
    logic [W:0]   sat;
    logic         under;

    always_comb begin
        sum   = {1'b0, cnt_q} + {1'b0, ret_amt};
        sat   = (sum > MAXV) ? MAXV : sum;
        under = ({1'b0, use_amt} > sat);
        uflow = !rst && !load && !inf_q && under;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            inf_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            inf_q <= load_inf;
        end else if (!inf_q) begin
            if (under)
                cnt_q <= '0;
            else
                cnt_q <= W'(sat - {1'b0, use_amt});
        end
    end

    assign cnt = cnt_q;
    assign inf = inf_q;

    // R6: an infinite counter does not move without a new load
    a_r6_inf_hold: assert property (@(posedge clk) disable iff (rst)
        (inf_q && !load) |=> $stable(cnt_q));

    // R10: reset leaves a cleared, finite counter
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && !inf_q));

    // R9: an underflow lands on zero
    a_r9_floor: assert property (@(posedge clk) disable iff (rst)
        uflow |=> (cnt_q == '0));
endmodule

// File: rtl/txfc_status_enc.sv
module txfc_status_enc
    import txfc_pkg::*;
#(
    parameter int HDR_W = 8,
    parameter int DAT_W = 12
) (
    input  logic [HDR_W-1:0] ph_cnt,
    input  logic             ph_inf,
    input  logic [DAT_W-1:0] pd_cnt,
    input  logic             pd_inf,
    input  logic [HDR_W-1:0] nph_cnt,
    input  logic             nph_inf,
    output credit_status_t   status
);
    always_comb begin
        status.ph_ok  = ph_inf  || (ph_cnt  != '0);
        status.nph_ok = nph_inf || (nph_cnt != '0);
        status.pd_cnt = pd_inf ? PD_FIELD_W'(PD_FIELD_MAX)
                               : clamp_pd_field(32'(pd_cnt));
    end
endmodule

// File: rtl/txfc_credit_tracker.sv
module txfc_credit_tracker
    import txfc_pkg::*;
#(
    parameter int HDR_W = 8,
    parameter int DAT_W = 12,
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_load,
    input  logic [HDR_W-1:0] adv_ph,
    input  logic [DAT_W-1:0] adv_pd,
    input  logic [HDR_W-1:0] adv_nph,
    input  logic             adv_ph_inf,
    input  logic             adv_pd_inf,
    input  logic             adv_nph_inf,
    input  logic [HDR_W-1:0] rtn_ph,
    input  logic [DAT_W-1:0] rtn_pd,
    input  logic [HDR_W-1:0] rtn_nph,
    input  logic             pkt_accept,
    input  logic             pkt_kind,
    input  logic [LEN_W-1:0] pkt_len_bytes,
    output logic [10:0]      credit_status,
    output logic             credit_uflow_err
);
    logic             is_posted;
    logic             is_np;
    logic [DAT_W-1:0] len_cred;
    logic [HDR_W-1:0] ph_use;
    logic [DAT_W-1:0] pd_use;
    logic [HDR_W-1:0] nph_use;
    logic [HDR_W-1:0] ph_cnt;
    logic [DAT_W-1:0] pd_cnt;
    logic [HDR_W-1:0] nph_cnt;
    logic             ph_inf;
    logic             pd_inf;
    logic             nph_inf;
    logic             ph_uf;
    logic             pd_uf;
    logic             nph_uf;
    logic             err_q;
    credit_status_t   status;

    assign is_posted = pkt_accept && (pkt_kind_e'(pkt_kind) == PKT_POSTED);
    assign is_np     = pkt_accept && (pkt_kind_e'(pkt_kind) == PKT_NONPOSTED);

    txfc_len2cred #(.LEN_W(LEN_W), .OUT_W(DAT_W)) u_len (
        .len_bytes (pkt_len_bytes),
        .credits   (len_cred)
    );

    assign ph_use  = HDR_W'(is_posted);
    assign nph_use = HDR_W'(is_np);
    assign pd_use  = is_posted ? len_cred : '0;

    txfc_credit_ctr #(.W(HDR_W)) u_ph (
        .clk(clk), .rst(rst), .load(adv_load), .load_val(adv_ph),
        .load_inf(adv_ph_inf), .ret_amt(rtn_ph), .use_amt(ph_use),
        .cnt(ph_cnt), .inf(ph_inf), .uflow(ph_uf)
    );

    txfc_credit_ctr #(.W(DAT_W)) u_pd (
        .clk(clk), .rst(rst), .load(adv_load), .load_val(adv_pd),
        .load_inf(adv_pd_inf), .ret_amt(rtn_pd), .use_amt(pd_use),
        .cnt(pd_cnt), .inf(pd_inf), .uflow(pd_uf)
    );

    txfc_credit_ctr #(.W(HDR_W)) u_nph (
        .clk(clk), .rst(rst), .load(adv_load), .load_val(adv_nph),
        .load_inf(adv_nph_inf), .ret_amt(rtn_nph), .use_amt(nph_use),
        .cnt(nph_cnt), .inf(nph_inf), .uflow(nph_uf)
    );

    txfc_status_enc #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_enc (
        .ph_cnt(ph_cnt), .ph_inf(ph_inf),
        .pd_cnt(pd_cnt), .pd_inf(pd_inf),
        .nph_cnt(nph_cnt), .nph_inf(nph_inf),
        .status(status)
    );

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (ph_uf || pd_uf || nph_uf)
            err_q <= 1'b1;
    end

    assign credit_status    = status;
    assign credit_uflow_err = err_q;

    // R2: the data field never shows a reserved code
    a_r2_pd_cap: assert property (@(posedge clk) disable iff (rst)
        credit_status[9:1] <= 9'd256);

    // R1: posted-header flag tracks its counter
    a_r1_ph_flag: assert property (@(posedge clk) disable iff (rst)
        credit_status[0] == (ph_inf || (ph_cnt != '0)));

    // R3: non-posted-header flag tracks its counter
    a_r3_nph_flag: assert property (@(posedge clk) disable iff (rst)
        credit_status[10] == (nph_inf || (nph_cnt != '0)));

    // R9: the error flag is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        credit_uflow_err |=> credit_uflow_err);
endmodule

// File: tb/sim_txfc_credit_tracker.sv
`timescale 1ns/1ps
module sim_txfc_credit_tracker;
    localparam int HMAX = 255;
    localparam int DMAX = 4095;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_load = 1'b0;
    logic [7:0]  adv_ph = '0;
    logic [11:0] adv_pd = '0;
    logic [7:0]  adv_nph = '0;
    logic        adv_ph_inf = 1'b0, adv_pd_inf = 1'b0, adv_nph_inf = 1'b0;
    logic [7:0]  rtn_ph = '0;
    logic [11:0] rtn_pd = '0;
    logic [7:0]  rtn_nph = '0;
    logic        pkt_accept = 1'b0, pkt_kind = 1'b0;
    logic [12:0] pkt_len_bytes = '0;
    logic [10:0] credit_status;
    logic        credit_uflow_err;

    int total = 0, bad = 0;
    bit done = 0;
    int m_ph = 0, m_pd = 0, m_nph = 0;
    bit m_ph_inf = 0, m_pd_inf = 0, m_nph_inf = 0, m_err = 0;

    always #2.5 clk = ~clk;

    txfc_credit_tracker u0 (
        .clk(clk), .rst(rst), .adv_load(adv_load),
        .adv_ph(adv_ph), .adv_pd(adv_pd), .adv_nph(adv_nph),
        .adv_ph_inf(adv_ph_inf), .adv_pd_inf(adv_pd_inf), .adv_nph_inf(adv_nph_inf),
        .rtn_ph(rtn_ph), .rtn_pd(rtn_pd), .rtn_nph(rtn_nph),
        .pkt_accept(pkt_accept), .pkt_kind(pkt_kind), .pkt_len_bytes(pkt_len_bytes),
        .credit_status(credit_status), .credit_uflow_err(credit_uflow_err)
    );

    function automatic void upd(inout int c, input bit inf, input int ret,
                                input int use_n, input int mx, inout bit err);
        int s;
        if (inf) return;
        s = c + ret;
        if (s > mx) s = mx;
        if (use_n > s) begin c = 0; err = 1; end
        else c = s - use_n;
    endfunction

    function automatic int expected_status();
        int pdf;
        pdf = m_pd_inf ? 256 : (m_pd > 256 ? 256 : m_pd);
        return ((m_nph_inf || m_nph != 0) ? 1024 : 0) + (pdf << 1)
             + ((m_ph_inf || m_ph != 0) ? 1 : 0);
    endfunction

    task automatic check(input string tag);
        int e;
        e = expected_status();
        total++;
        if (credit_status !== 11'(e) || credit_uflow_err !== m_err) begin
            bad++;
            $display("FAIL %s: status=%h err=%0b expected status=%h err=%0b",
                     tag, credit_status, credit_uflow_err, 11'(e), m_err);
        end
    endtask

    task automatic step(input bit ld, input int lph, input int lpd, input int lnph,
                        input bit iph, input bit ipd, input bit inph,
                        input int rph, input int rpd, input int rnph,
                        input bit acc, input bit np, input int len, input string tag);
        @(negedge clk);
        adv_load = ld; adv_ph = 8'(lph); adv_pd = 12'(lpd); adv_nph = 8'(lnph);
        adv_ph_inf = iph; adv_pd_inf = ipd; adv_nph_inf = inph;
        rtn_ph = 8'(rph); rtn_pd = 12'(rpd); rtn_nph = 8'(rnph);
        pkt_accept = acc; pkt_kind = np; pkt_len_bytes = 13'(len);
        @(posedge clk);
        #1;
        if (ld) begin
            m_ph = lph; m_pd = lpd; m_nph = lnph;
            m_ph_inf = iph; m_pd_inf = ipd; m_nph_inf = inph;
        end else begin
            upd(m_ph, m_ph_inf, rph, (acc && !np) ? 1 : 0, HMAX, m_err);
            upd(m_pd, m_pd_inf, rpd, (acc && !np) ? (len + 15) / 16 : 0, DMAX, m_err);
            upd(m_nph, m_nph_inf, rnph, (acc && np) ? 1 : 0, HMAX, m_err);
        end
        check(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        adv_load = 0; pkt_accept = 0;
        rtn_ph = '0; rtn_pd = '0; rtn_nph = '0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        m_ph = 0; m_pd = 0; m_nph = 0;
        m_ph_inf = 0; m_pd_inf = 0; m_nph_inf = 0; m_err = 0;
        check("R10 reset");
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11: load, data field clamped per R2
        step(1, 3, 300, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 load");
        // R4: exact data deductions, incl. boundaries 0,1,16,17
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0,  "R4 len0");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1,  "R4 len1");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 16, "R4 len16");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 17, "R1 ph drained");
        // R5: non-posted ignores length, touches only nph
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 4096, "R5 np");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0,    "R3 nph drained");
        // R7/R8: long posted sweep with same-cycle returns
        step(1, 200, 4000, 100, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 reload");
        for (int l = 0; l <= 700; l++)
            step(0, 0, 0, 0, 0, 0, 0, l % 2, (l * 7) % 41, 0, 1, 0, l, "R7 sweep");
        // R5 sweep of non-posted with returns
        for (int l = 0; l < 300; l++)
            step(0, 0, 0, 0, 0, 0, 0, 0, 0, l % 3, 1, 1, l * 13, "R5 sweep");
        // R8: saturation then drain shows 255 only if saturated
        do_reset();
        step(1, 250, 4000, 250, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 load sat");
        step(0, 0, 0, 0, 0, 0, 0, 100, 4095, 100, 0, 0, 0, "R8 saturate");
        step(0, 0, 0, 0, 0, 0, 0, 100, 4095, 100, 0, 0, 0, "R8 saturate again");
        for (int k = 0; k < 15; k++)
            step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 4096, "R8 drain");
        // R9: underflow clamps and sticks
        do_reset();
        step(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 small load");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 100, "R9 underflow");
        idle("R9 sticky");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, "R9 nph underflow");
        step(0, 0, 0, 0, 0, 0, 0, 5, 5, 5, 0, 0, 0, "R9 sticky after return");
        // R6: infinite types
        do_reset();
        step(1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R6 inf load");
        for (int l = 0; l < 40; l++)
            step(0, 0, 0, 0, 0, 0, 0, 9, 99, 9, 1, l[0], l * 200, "R6 inf hold");
        // R6 mixed: only data infinite
        step(1, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R6 pd inf only");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 4096, "R6 pd inf, ph drains");
        // R11: load wins over same-cycle accept and return
        step(1, 2, 10, 2, 0, 0, 0, 50, 50, 50, 1, 0, 160, "R11 load priority");
        idle("R11 hold after load");
        // R10: reset clears infinite flags
        step(1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R6 inf reload");
        do_reset();
        idle("R10 post reset idle");
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule